// File: doc/BRIEF.md
# Byte-Wide SPI Port with Select-Line Contention Guard

This block is a one-byte SPI port for a processor's register bus. Software sets the role with a control register. As a master, the port makes a mode-0 serial clock from the system clock with a small divider. It shifts one byte out on MOSI and one byte in from MISO. As a slave, it follows an external serial clock while an active-low select input is held low. It shifts a preloaded byte out on MISO and gathers the incoming byte from MOSI. Bit order is MSB first unless the LSB-first control bit is set.

In master mode the select pin has two uses, chosen by a control bit. Configured as an output, it is a plain output driven from a register bit and does not affect the transfer logic. Configured as an input, it watches for another master. If that pin goes low, the port assumes a second master is claiming the bus. It clears its own master bit, releases SCK and MOSI, and raises the completion flag so that software sees the event. In slave mode, raising select at any point cancels the byte in progress and resets the bit counter.

One interrupt output is driven by the completion flag, gated by a local enable and a global enable input.

Top module: `spi_port`

## Requirements
- R1: Register offsets are 0 control, 1 status, 2 data and 3 select level. Control bits are: bit7 interrupt enable, bit6 port enable, bit5 LSB-first, bit4 master, bit3 select-as-output, bits 2:0 divider. Status bit7 is transfer complete and bit6 is collision; writes to status have no effect. Bit0 of offset 3 is the select output level. After reset every register reads zero and every output enable is low.
- R2: In master mode, a data write while idle starts a transfer. SCK idles low and gives 8 pulses. MOSI shows each bit before its rising edge, MSB first. MISO is sampled on each rising edge, and the received byte then reads back from offset 2.
- R3: With the LSB-first bit set, both the sent and the received byte use bit 0 first.
- R4: Every SCK high phase, and every low phase between pulses, lasts divider+1 system clock cycles.
- R5: The end of a transfer sets the complete flag. The interrupt output is high exactly when complete, the interrupt enable and the global enable input are all high.
- R6: A status read that returns complete=1, followed by a data access, clears both complete and collision. A data access with no such status read first leaves the flags set.
- R7: A data write while a transfer is running sets the collision flag. It does not disturb the byte being sent and does not start a new transfer.
- R8: In slave mode with select low, the port shifts on the external SCK. It drives the byte last written to offset 2 out on MISO with MISO's output enable high, and captures MOSI into the data register.
- R9: In slave mode with select high, every output enable is low and SCK edges are ignored: the complete flag stays clear and the data register keeps its value.
- R10: In slave mode, raising select in the middle of a byte discards the partial byte and resets the bit count. The next full byte is received correctly and sends the preloaded byte again from its first bit.
- R11: In master mode with select configured as an input, a low on select clears the master bit, drops the SCK and MOSI output enables, aborts any transfer and sets the complete flag.
- R12: After such a demotion the port stays a slave until software writes the master bit to 1 again.
- R13: In master mode with select configured as an output, the select pin is driven with the offset 3 level and its enable is high. A low on the select input then neither demotes the port nor stops a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the pin |
| sck_o | output | 1 | Serial clock to the pin |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI from the pin |
| mosi_o | output | 1 | MOSI to the pin |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the pin |
| miso_o | output | 1 | MISO to the pin |
| miso_oe | output | 1 | MISO output enable |
| sel_n_i | input | 1 | Active-low select from the pin |
| sel_o | output | 1 | Select level to the pin |
| sel_oe | output | 1 | Select output enable |

## Verification
The hardest states to reach are the ones where the select pin acts on a transfer already underway: a demotion that takes mastership away, or a deselect that drops a half-shifted byte. Both leave no trace in the data path that simple traffic would reveal. The bench drives the pins at bit level and raises select after exactly three slave bits. It then confirms that the data register kept its old value and that the next full byte arrives intact, with the preloaded byte resent from its first bit. For the demotion, it pulls select low under an active master with interrupts enabled. It then reads back the control register to confirm the master bit stays clear after select returns high, until software rewrites it.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 3;

    typedef struct packed {
        logic             irq_en;
        logic             port_en;
        logic             lsb_first;
        logic             master;
        logic             sel_out;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_SEL  = 2'd3
    } reg_addr_e;

    function automatic logic [BYTE_W-1:0] shift_in(input logic lsb,
                                                  input logic [BYTE_W-1:0] cur,
                                                  input logic b);
        if (lsb) return {b, cur[BYTE_W-1:1]};
        return {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic head_bit(input logic lsb, input logic [BYTE_W-1:0] cur);
        return lsb ? cur[0] : cur[BYTE_W-1];
    endfunction

endpackage

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt_q <= '0;
        else if (cnt_q == div) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter
    import spi_port_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample,
    input  logic         shift,
    input  logic         in_bit,
    input  logic         lsb,
    output logic         out_bit,
    output logic         cnt_zero,
    output logic         byte_done,
    output logic [W-1:0] rx_val
);
    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rbit_q;

    assign rx_val    = shift_in(lsb, sh_q, rbit_q);
    assign out_bit   = head_bit(lsb, sh_q);
    assign cnt_zero  = (cnt_q == '0);
    assign byte_done = shift && !clear && !load && (cnt_q == CNT_W'(W-1));

    always_ff @(posedge clk) begin
        if (rst)         rbit_q <= 1'b0;
        else if (sample) rbit_q <= in_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= rx_val;
            cnt_q <= (cnt_q == CNT_W'(W-1)) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              gie,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              sel_n_i,
    output logic              sel_o,
    output logic              sel_oe
);
    ctrl_t             ctrl_q;
    logic              sel_lvl_q;
    logic              busy_q, sck_q;
    logic              done_q, coll_q, arm_q;
    logic [BYTE_W-1:0] rx_q, tx_q;
    logic [1:0]        sck_sy, sel_sy;

    logic sel_now, sck_rise, sck_fall;
    logic master_act, slave_act, fault;
    logic wr_ctrl, wr_data, rd_data, rd_stat, wr_sel;
    logic busy_any, start, tick, m_sample, m_shift;
    logic sh_clear, sh_load, sample, shift, in_bit;
    logic out_bit, cnt_zero, xfer_done;
    logic [BYTE_W-1:0] rx_val, load_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy <= 2'b00;
            sel_sy <= 2'b11;
        end else begin
            sck_sy <= {sck_sy[0], sck_i};
            sel_sy <= {sel_sy[0], sel_n_i};
        end
    end

    assign sel_now  = sel_sy[0];
    assign sck_rise = sck_sy[0] & ~sck_sy[1];
    assign sck_fall = ~sck_sy[0] & sck_sy[1];

    assign master_act = ctrl_q.port_en & ctrl_q.master;
    assign slave_act  = ctrl_q.port_en & ~ctrl_q.master & ~sel_now;
    assign fault      = master_act & ~ctrl_q.sel_out & ~sel_now;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign wr_sel  = reg_wr && (reg_addr == A_SEL);
    assign rd_data = reg_rd && (reg_addr == A_DATA);
    assign rd_stat = reg_rd && (reg_addr == A_STAT);

    assign busy_any = master_act ? busy_q : ~cnt_zero;
    assign start    = wr_data & master_act & ~busy_q & ~fault;

    spi_port_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .run (busy_q & master_act),
        .div (ctrl_q.div),
        .tick(tick)
    );

    assign m_sample = busy_q & tick & ~sck_q;
    assign m_shift  = busy_q & tick & sck_q;
    assign sample   = master_act ? m_sample : (slave_act & sck_rise);
    assign shift    = master_act ? m_shift  : (slave_act & sck_fall);
    assign in_bit   = master_act ? miso_i : mosi_i;
    assign sh_clear = fault | ~ctrl_q.port_en | (~ctrl_q.master & sel_now);
    assign sh_load  = start | (slave_act & cnt_zero & ~shift);
    assign load_val = start ? reg_wdata : tx_q;

    spi_port_shifter #(.W(BYTE_W)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .clear    (sh_clear),
        .load     (sh_load),
        .load_val (load_val),
        .sample   (sample),
        .shift    (shift),
        .in_bit   (in_bit),
        .lsb      (ctrl_q.lsb_first),
        .out_bit  (out_bit),
        .cnt_zero (cnt_zero),
        .byte_done(xfer_done),
        .rx_val   (rx_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
        end else if (fault || !master_act) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
        end else if (m_sample) begin
            sck_q <= 1'b1;
        end else if (m_shift) begin
            sck_q <= 1'b0;
            if (xfer_done) busy_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            sel_lvl_q <= 1'b0;
            tx_q      <= '0;
            rx_q      <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
            if (fault)   ctrl_q.master <= 1'b0;
            if (wr_sel)  sel_lvl_q <= reg_wdata[0];
            if (wr_data && !master_act && !busy_any) tx_q <= reg_wdata;
            if (xfer_done) rx_q <= rx_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            coll_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if ((rd_data || wr_data) && arm_q) begin
                done_q <= 1'b0;
                coll_q <= 1'b0;
                arm_q  <= 1'b0;
            end
            if (rd_stat && done_q)    arm_q  <= 1'b1;
            if (xfer_done || fault)   done_q <= 1'b1;
            if (wr_data && busy_any)  coll_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_STAT:  reg_rdata = {done_q, coll_q, {(BYTE_W-2){1'b0}}};
            A_DATA:  reg_rdata = rx_q;
            default: reg_rdata = {{(BYTE_W-1){1'b0}}, sel_lvl_q};
        endcase
    end

    assign irq     = done_q & ctrl_q.irq_en & gie;
    assign sck_o   = sck_q;
    assign sck_oe  = master_act;
    assign mosi_o  = out_bit;
    assign mosi_oe = master_act;
    assign miso_o  = out_bit;
    assign miso_oe = slave_act;
    assign sel_o   = sel_lvl_q;
    assign sel_oe  = master_act & ctrl_q.sel_out;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst,
    input logic master,
    input logic port_en,
    input logic sel_out,
    input logic sel_now,
    input logic sel_n_i,
    input logic miso_oe,
    input logic sck_o,
    input logic busy,
    input logic done,
    input logic coll,
    input logic wr_data,
    input logic wr_ctrl,
    input logic busy_any
);
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck_o);  // R2
    AST_DESEL_NO_MISO: assert property (@(posedge clk) disable iff (rst)
        (!master && sel_n_i) |=> !miso_oe);  // R9
    AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (rst)
        (port_en && master && !sel_out && !sel_now) |=> (!master && done));  // R11
    AST_COLLISION_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy_any) |=> coll);  // R7
    AST_SLAVE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!master && !wr_ctrl) |=> !master);  // R12
    AST_SELOUT_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (port_en && master && sel_out && !wr_ctrl) |=> master);  // R13
endmodule

bind spi_port spi_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .master  (ctrl_q.master),
    .port_en (ctrl_q.port_en),
    .sel_out (ctrl_q.sel_out),
    .sel_now (sel_now),
    .sel_n_i (sel_n_i),
    .miso_oe (miso_oe),
    .sck_o   (sck_o),
    .busy    (busy_q),
    .done    (done_q),
    .coll    (coll_q),
    .wr_data (wr_data),
    .wr_ctrl (wr_ctrl),
    .busy_any(busy_any)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       irq;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, sel_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, sel_o, sel_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_port u_spi_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gie(gie), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .sel_n_i(sel_n_i), .sel_o(sel_o), .sel_oe(sel_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input logic ie, input logic en, input logic lsb,
                                       input logic m, input logic so, input logic [2:0] dv);
        return {ie, en, lsb, m, so, dv};
    endfunction

    function automatic logic bitof(input logic [7:0] v, input int i, input logic lsb);
        if (i > 7) return 1'b0;
        return lsb ? v[i] : v[7-i];
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // data read without arming, then the clearing sequence (R6)
    task automatic flag_seq(input logic [7:0] exp_rx, input logic exp_coll, input string req);
        logic [7:0] v;
        rd(2'd2, v);  chk(req, v, exp_rx);
        rd(2'd1, v);  chk("R6 flag kept without status read", v, {1'b1, exp_coll, 6'b0});
        rd(2'd2, v);
        rd(2'd1, v);  chk("R6 flags cleared", v, 8'h00);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] pat, input logic lsb,
                               input logic [2:0] dv, input logic so, input logic coll);
        int falls = 0, rises = 0, hi = 0, lo = 0;
        logic prev = 1'b0, did = 1'b0;
        logic [7:0] got = 8'h00;
        wr(2'd0, ctl(1'b0, 1'b1, lsb, 1'b1, so, dv));
        miso_i = bitof(pat, 0, lsb);
        wr(2'd2, tx);
        while (falls < 8) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if (sck_o && !prev) begin
                if (lsb) got[rises] = mosi_o; else got[7-rises] = mosi_o;
                if (rises > 0) chk("R4 low phase", 8'(lo), 8'(dv + 1));
                rises++;
                hi = 1;
            end else if (sck_o) hi++;
            if (!sck_o && prev) begin
                chk("R4 high phase", 8'(hi), 8'(dv + 1));
                falls++;
                lo = 1;
                miso_i = bitof(pat, falls, lsb);
            end else if (!sck_o) lo++;
            prev = sck_o;
            if (coll && !did && falls == 2) begin
                reg_addr = 2'd2; reg_wdata = ~tx; reg_wr = 1'b1; did = 1'b1;
            end
        end
        repeat (3) @(negedge clk);
        chk("R2 sck idle low", {7'b0, sck_o}, 8'h00);
        chk(lsb ? "R3 sent byte" : "R2 sent byte", got, tx);
        chk("R2 single transfer only", {7'b0, sck_o}, 8'h00);
        flag_seq(pat, coll, lsb ? "R3 received byte" : "R2 received byte");
    endtask

    task automatic slave_bits(input logic [7:0] pat, input logic lsb, input int nbits,
                              output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            mosi_i = bitof(pat, i, lsb);
            repeat (4) @(negedge clk);
            if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
            sck_i = 1'b1;
            repeat (4) @(negedge clk);
            sck_i = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic slave_xfer(input logic [7:0] pat, input logic [7:0] tx, input logic lsb,
                              input string req);
        logic [7:0] got;
        @(negedge clk); sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 miso enabled when selected", {7'b0, miso_oe}, 8'h01);
        slave_bits(pat, lsb, 8, got);
        sel_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 miso released when deselected", {7'b0, miso_oe}, 8'h00);
        chk(req, got, tx);
        flag_seq(pat, 1'b0, "R8 slave received byte");
    endtask

    initial begin
        logic [31:0] r;
        logic [7:0]  v;
        r = $urandom(32'd1234);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
        rd(2'd1, v); chk("R1 status reset", v, 8'h00);
        rd(2'd3, v); chk("R1 select level reset", v, 8'h00);
        chk("R1 enables low after reset", {4'b0, sck_oe, mosi_oe, miso_oe, sel_oe}, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R1 status not writable", v, 8'h00);

        // directed master transfers
        master_xfer(8'hA5, 8'h3C, 1'b0, 3'd0, 1'b0, 1'b0);
        master_xfer(8'h81, 8'h96, 1'b1, 3'd2, 1'b0, 1'b0);
        master_xfer(8'h5A, 8'hC3, 1'b0, 3'd1, 1'b0, 1'b1);  // R7 collision mid-byte

        // interrupt gating R5
        wr(2'd0, ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0));
        miso_i = 1'b0;
        wr(2'd2, 8'h11);
        repeat (30) @(negedge clk);
        chk("R5 irq low without global enable", {7'b0, irq}, 8'h00);
        gie = 1'b1; #1;
        chk("R5 irq with flag and enables", {7'b0, irq}, 8'h01);
        rd(2'd1, v); rd(2'd2, v);
        chk("R5 irq clears with flag", {7'b0, irq}, 8'h00);

        // random master traffic
        for (int n = 0; n < 10; n++) begin
            logic [7:0] tx, pat;
            logic lsb;
            logic [2:0] dv;
            r = $urandom; tx = r[7:0]; pat = r[15:8]; lsb = r[16]; dv = {1'b0, r[18:17]};
            master_xfer(tx, pat, lsb, dv, 1'b0, 1'b0);
        end

        // slave mode
        gie = 1'b0;
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0));
        wr(2'd2, 8'hE7);
        slave_xfer(8'h4B, 8'hE7, 1'b0, "R8 slave sent byte msb");
        wr(2'd0, ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0));
        wr(2'd2, 8'h1D);
        slave_xfer(8'hB2, 8'h1D, 1'b1, "R8 slave sent byte lsb");

        // R9: clocks with select high are ignored
        for (int i = 0; i < 8; i++) begin
            mosi_i = i[0];
            repeat (4) @(negedge clk); sck_i = 1'b1;
            repeat (4) @(negedge clk); sck_i = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk("R9 all enables low deselected", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);
        rd(2'd1, v); chk("R9 no completion deselected", v, 8'h00);
        rd(2'd2, v); chk("R9 data kept deselected", v, 8'hB2);

        // R10: partial byte then deselect
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0));
        wr(2'd2, 8'h69);
        @(negedge clk); sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        slave_bits(8'hFF, 1'b0, 3, v);
        sel_n_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R10 no completion after abort", v, 8'h00);
        rd(2'd2, v); chk("R10 partial byte discarded", v, 8'hB2);
        slave_xfer(8'h2E, 8'h69, 1'b0, "R10 resend from first bit");

        // R11 / R12: mode fault
        gie = 1'b1;
        wr(2'd0, ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1));
        chk("R11 sck driven as master", {7'b0, sck_oe}, 8'h01);
        @(negedge clk); sel_n_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 sck and mosi released", {6'b0, sck_oe, mosi_oe}, 8'h00);
        chk("R5 irq on mode fault", {7'b0, irq}, 8'h01);
        rd(2'd0, v); chk("R11 master bit cleared", v, 8'hC1);
        rd(2'd1, v); chk("R11 complete flag set", v, 8'h80);
        rd(2'd2, v);
        sel_n_i = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R12 remains slave", v, 8'hC1);
        chk("R12 sck still released", {7'b0, sck_oe}, 8'h00);
        wr(2'd0, ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1));
        chk("R12 master restored by write", {7'b0, sck_oe}, 8'h01);
        gie = 1'b0;

        // R13: select pin as output
        wr(2'd3, 8'h00);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0));
        chk("R13 select driven low", {6'b0, sel_oe, sel_o}, 8'h02);
        @(negedge clk); sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R13 no demotion", v, 8'h58);
        master_xfer(8'hC6, 8'h71, 1'b0, 3'd0, 1'b1, 1'b0);
        wr(2'd3, 8'h01);
        chk("R13 select driven high", {6'b0, sel_oe, sel_o}, 8'h03);
        sel_n_i = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule